// File: doc/BRIEF.md
# Bus Grant Daisy-Chain Requester

This block sits in each module on a backplane that shares one bus through four prioritised request levels. Each level has an open-collector request line and a grant daisy chain. The chain starts at the arbiter in slot one and passes from module to module. When the local master needs the bus, the block pulls the request line of its home level. It then watches the grant input of that level. If the grant is for this module, the block keeps it and reports ownership. Otherwise, and on every other level, the block copies the grant to its grant output for the next module downstream. The grant outputs are totem-pole, so they are always driven.

All chain inputs pass through a synchroniser chain before any decision uses them. The grant outputs are registered. When the master lets go of the bus, the request is withdrawn. The block then refuses to request again until the grant it held has been taken back by the arbiter.

The request vector `req_pull` is active high: a 1 means "drive this open-collector line low" and a 0 means "release it". `grant_in` and `grant_out` are also active high: a 1 means the grant of that level is present. Any inversion to and from the active-low backplane pins is done at the pads.

Top module: `bg_chain_requester`

## Requirements
- R1: After reset, `grant_out`, `req_pull` and `owned` are all 0.
- R2: One clock edge after `want_bus` is seen high in the idle state, `req_pull` has exactly bit `home_level` set. No more than one bit of `req_pull` is ever set.
- R3: On a level that this module is not holding, a change of `grant_in[l]` appears on `grant_out[l]` exactly three clock edges later. This applies to both assertion and negation: two synchroniser stages plus one output register.
- R4: Grants on the three non-home levels keep passing through while the module requests or owns the bus.
- R5: In the requesting state, a home-level grant that is not already being passed downstream sets `owned` three edges after `grant_in` rises. `grant_out` for that level stays 0 while the module holds the grant.
- R6: If the home-level grant is already being passed downstream when a request is raised, the block keeps passing it until it negates. It takes ownership only on the next home-level grant.
- R7: When `want_bus` falls while `owned` is 1, `owned` and `req_pull` both fall on the next edge.
- R8: After a release, `req_pull` stays 0 and the home-level grant is not passed downstream until the synchronised home grant has negated. The request then reappears one edge after the block returns to idle if `want_bus` is still high.
- R9: When `want_bus` falls before a grant arrives, `req_pull` falls on the next edge and no ownership is taken.
- R10: The home level is captured when a request starts. A change of `home_level` while the block is requesting, owning or holding off has no effect until it is idle again.
- R11: While `owned` is 1, `req_pull` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| home_level | input | LVL_W (2) | Level this module requests on |
| want_bus | input | 1 | Local master needs the bus (held high for the whole tenure) |
| grant_in | input | LEVELS (4) | Grant from upstream, one bit per level, 1 = grant present |
| grant_out | output | LEVELS (4) | Grant to downstream, one bit per level, always driven |
| req_pull | output | LEVELS (4) | 1 = pull that request line low |
| owned | output | 1 | This module holds the bus |

## Verification
The assertions assume three things about the inputs. First, `want_bus` is a level held for the whole tenure, not a pulse. Second, the arbiter keeps a home-level grant present for as long as the module owns the bus. Third, grant inputs change slowly enough that each value is seen by the synchroniser.

The stimulus respects all three. Every input is moved on the falling clock edge. Each grant is held for at least three edges before it changes. `want_bus` is dropped only after the expected state has been checked.

The sweep repeats the same sequence for every home level: request, capture, release, holdoff, withdrawal and a grant that was already passing. During each run the other three levels carry grants, so pass-through is checked at the same time as ownership.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
   typedef enum logic [1:0] {
      RQ_IDLE = 2'd0,
      RQ_WAIT = 2'd1,
      RQ_OWN  = 2'd2,
      RQ_HOLD = 2'd3
   } rq_state_t;
endpackage

// File: rtl/bgc_sync.sv
module bgc_sync #(
   parameter int LEVELS      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEVELS-1:0] raw_in,
   output logic [LEVELS-1:0] sync_out
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("bgc_sync: SYNC_STAGES must be at least 2");
   end

   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw_in[l]};
      end
      assign sync_out[l] = chain_q[SYNC_STAGES-1];
   end
endmodule

// File: rtl/bgc_fsm.sv
module bgc_fsm
   import bgc_pkg::*;
#(
   parameter int LEVELS = 4,
   localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  home_level,
   input  logic              want_bus,
   input  logic [LEVELS-1:0] gin_s,
   input  logic [LEVELS-1:0] passing,
   output logic [LEVELS-1:0] claim_mask,
   output logic [LEVELS-1:0] req_pull,
   output logic              owned
);
   rq_state_t        state_q, state_d;
   logic [LVL_W-1:0] lvl_q;
   logic [LEVELS-1:0] lvl_onehot;
   logic             home_gnt, home_pass;

   assign lvl_onehot = LEVELS'(1) << lvl_q;
   assign home_gnt   = gin_s[lvl_q];
   assign home_pass  = passing[lvl_q];

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         RQ_IDLE: if (want_bus) state_d = RQ_WAIT;
         RQ_WAIT: begin
            if (!want_bus)                    state_d = RQ_IDLE;
            else if (home_gnt && !home_pass)  state_d = RQ_OWN;
         end
         RQ_OWN:  if (!want_bus) state_d = RQ_HOLD;
         RQ_HOLD: if (!home_gnt) state_d = RQ_IDLE;
         default: state_d = RQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RQ_IDLE;
         lvl_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == RQ_IDLE) lvl_q <= home_level;
      end
   end

   assign claim_mask = (state_q != RQ_IDLE) ? lvl_onehot : '0;
   assign req_pull   = (state_q == RQ_WAIT || state_q == RQ_OWN) ? lvl_onehot : '0;
   assign owned      = (state_q == RQ_OWN);
endmodule

// File: rtl/bgc_pass.sv
module bgc_pass #(
   parameter int LEVELS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEVELS-1:0] gin_s,
   input  logic [LEVELS-1:0] claim_mask,
   output logic [LEVELS-1:0] grant_out
);
   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      logic out_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_q <= 1'b0;
         else        out_q <= gin_s[l] & (out_q | ~claim_mask[l]);
      end
      assign grant_out[l] = out_q;
   end
endmodule

// File: rtl/bg_chain_requester.sv
module bg_chain_requester #(
   parameter int LEVELS      = 4,
   parameter int SYNC_STAGES = 2,
   localparam int LVL_W      = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  home_level,
   input  logic              want_bus,
   input  logic [LEVELS-1:0] grant_in,
   output logic [LEVELS-1:0] grant_out,
   output logic [LEVELS-1:0] req_pull,
   output logic              owned
);
   if (LEVELS < 2) begin : g_bad_levels
      $error("bg_chain_requester: LEVELS must be at least 2");
   end

   logic [LEVELS-1:0] gin_s, claim_mask;

   bgc_sync #(.LEVELS(LEVELS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw_in(grant_in), .sync_out(gin_s));

   bgc_fsm #(.LEVELS(LEVELS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .home_level(home_level), .want_bus(want_bus),
      .gin_s(gin_s), .passing(grant_out), .claim_mask(claim_mask),
      .req_pull(req_pull), .owned(owned));

   bgc_pass #(.LEVELS(LEVELS)) u_pass (
      .clk(clk), .rst_n(rst_n), .gin_s(gin_s), .claim_mask(claim_mask),
      .grant_out(grant_out));
endmodule

// File: rtl/bg_chain_requester_chk.sv
module bg_chain_requester_chk #(
   parameter int LEVELS = 4,
   parameter int LVL_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LVL_W-1:0]  home_level,
   input logic              want_bus,
   input logic [LEVELS-1:0] grant_in,
   input logic [LEVELS-1:0] grant_out,
   input logic [LEVELS-1:0] req_pull,
   input logic              owned
);
   p_req_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_pull));

   p_req_needs_want_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_pull != '0) |-> $past(want_bus));

   p_own_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(owned) |-> $past(req_pull) != '0);

   p_no_pass_home_r5: assert property (@(posedge clk) disable iff (!rst_n)
      owned |-> (grant_out & req_pull) == '0);

   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (owned && !want_bus) |=> (!owned && req_pull == '0));

   p_owner_holds_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      owned |-> req_pull != '0);
endmodule

bind bg_chain_requester bg_chain_requester_chk #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .home_level(home_level), .want_bus(want_bus),
   .grant_in(grant_in), .grant_out(grant_out), .req_pull(req_pull), .owned(owned));

// File: tb/bg_chain_requester_bench.sv
module bg_chain_requester_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] home_level = '0;
   logic       want_bus = 1'b0;
   logic [3:0] grant_in = '0;
   logic [3:0] grant_out, req_pull;
   logic       owned;
   int         n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   bg_chain_requester u_bg_chain_requester (
      .clk(clk), .rst_n(rst_n), .home_level(home_level), .want_bus(want_bus),
      .grant_in(grant_in), .grant_out(grant_out), .req_pull(req_pull), .owned(owned));

   task automatic edges(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      edges(2);
      chk("R1 grant_out", grant_out, 4'h0);
      chk("R1 req_pull", req_pull, 4'h0);
      chk("R1 owned", {3'b0, owned}, 4'h0);
      rst_n = 1'b1;
      edges(2);
      for (int L = 0; L < 4; L++) begin
         logic [3:0] hm;
         hm = 4'(1 << L);
         home_level = 2'(L);
         want_bus = 1'b1;
         edges(1);
         chk("R2 request on home level", req_pull, hm);
         grant_in = 4'hF;
         edges(2);
         chk("R3 no grant_out before 3 edges", grant_out, 4'h0);
         edges(1);
         chk("R4 other levels pass", grant_out, ~hm);
         chk("R5 owned on home grant", {3'b0, owned}, 4'h1);
         home_level = 2'((L + 1) % 4);
         edges(2);
         chk("R10 level held while owning", req_pull, hm);
         home_level = 2'(L);
         want_bus = 1'b0;
         edges(1);
         chk("R7 owned drops", {3'b0, owned}, 4'h0);
         chk("R7 request drops", req_pull, 4'h0);
         want_bus = 1'b1;
         edges(3);
         chk("R8 no request in holdoff", req_pull, 4'h0);
         chk("R8 home grant blocked in holdoff", grant_out, ~hm);
         grant_in = 4'h0;
         edges(3);
         chk("R8 idle after grant negates", req_pull, 4'h0);
         edges(1);
         chk("R8 request again", req_pull, hm);
         want_bus = 1'b0;
         edges(1);
         chk("R9 withdraw request", req_pull, 4'h0);
         chk("R9 no ownership", {3'b0, owned}, 4'h0);
         grant_in = hm;
         edges(3);
         chk("R3 idle passes home grant", grant_out, hm);
         want_bus = 1'b1;
         edges(4);
         chk("R6 pass kept", grant_out, hm);
         chk("R6 no capture", {3'b0, owned}, 4'h0);
         chk("R6 still requesting", req_pull, hm);
         grant_in = 4'h0;
         edges(2);
         chk("R3 negation not yet seen", grant_out, hm);
         edges(1);
         chk("R3 negation after 3 edges", grant_out, 4'h0);
         grant_in = hm;
         edges(3);
         chk("R6 capture on fresh grant", {3'b0, owned}, 4'h1);
         chk("R5 home grant not passed", grant_out, 4'h0);
         chk("R11 owner holds request", req_pull, hm);
         want_bus = 1'b0;
         grant_in = 4'h0;
         edges(3);
         chk("R7 idle after release", {owned, req_pull[2:0]}, 4'h0);
         edges(1);
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule